// File: doc/BRIEF.md
# Two-Button Long-Press Recovery Detector

This block watches two active-low push-buttons, a main button and an auxiliary reset button, and recognises a deliberate long press of both as a request to recover a hung system. The main button must first stay down for a qualification time, which is the sum of a debounce count and a minimum-pulse count. Once that time has passed and both buttons are down, an extra-delay count runs. When that count completes, the block acts. The buttons may go down in either order. Releasing either one during the extra delay cancels the attempt at once.

A build parameter selects what happens on detection. In reset mode, a reset output is driven low for a recovery count. The power sequencer is then asked, with a one-cycle request, to run its hold-confirmation window again. In power-off mode, a power-off request is raised and held for an off-time count. After that it stays raised until the main button shows a fresh falling edge. All counts are runtime inputs in clock cycles. Counting only takes place while the normal-operation qualifier is high.

Top module: `long_push_det`

## Requirements
- R1: While reset is applied and just after it, `rst_pulse_n` is 1, `pwr_off_req` is 0 and `reconfirm_req` is 0.
- R2: With the auxiliary button already low, if the main button is first sampled low at clock edge e0 and both stay low, the outcome begins at edge e(Q+E), where Q = debounce_len + minpulse_len and E = extra_len. Q and E are each counted as at least 1, except that E = 0 behaves as R5 describes.
- R3: If the auxiliary button goes low only after Q has elapsed, the extra delay starts at the first edge where it is sampled low (edge a), and the outcome begins at edge a+E.
- R4: A release of either button during the extra delay aborts the attempt. No outcome follows until both buttons have been seen high together and a new press starts.
- R5: With extra_len = 0, the outcome begins at the same edge at which qualification completes with both buttons low.
- R6: In reset mode (FIRE_POWER_OFF = 0), `rst_pulse_n` stays low for max(recover_len,1) cycles. In the cycle after it rises, `reconfirm_req` is high for exactly one cycle.
- R7: In power-off mode (FIRE_POWER_OFF = 1), `pwr_off_req` rises at detection and holds for max(offtime_len,1) cycles. It is then cleared by the first high-to-low transition of `btn_main_n` sampled after that time. Transitions during the off time are ignored.
- R8: One press fires once. Keeping both buttons down after an outcome produces no further outcome until both have been released.
- R9: While `run_ok` is 0, no count runs and no outcome occurs.
- R10: If the main button is released during qualification, the count starts again from the next press.
- R11: In reset mode `pwr_off_req` is never raised. In power-off mode `rst_pulse_n` never goes low and `reconfirm_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_main_n | input | 1 | Main button, low when pressed |
| btn_aux_n | input | 1 | Auxiliary reset button, low when pressed |
| run_ok | input | 1 | High during normal operation; enables detection |
| debounce_len | input | CW | Debounce count in cycles |
| minpulse_len | input | CW | Minimum-pulse count in cycles |
| extra_len | input | CW | Extra-delay count in cycles; 0 means no extra delay |
| recover_len | input | CW | Reset pulse length in cycles |
| offtime_len | input | CW | Minimum off time in cycles |
| rst_pulse_n | output | 1 | Recovery reset, active low (reset mode) |
| pwr_off_req | output | 1 | Power-off request (power-off mode) |
| reconfirm_req | output | 1 | One-cycle request to rerun the hold-confirm window |

## Verification
The bench builds two instances that share stimulus: one with FIRE_POWER_OFF = 0 and one with FIRE_POWER_OFF = 1, both with CW = 16. This lets one press sequence exercise both outcomes and check that each mode leaves the other mode's outputs quiet. The runtime counts are kept small (debounce 3, minimum pulse 2, extra 4, recovery 5, off time 6), so that exact edge positions can be checked. The extra delay is also set to zero for one case. These values make the press-order, abort, re-arm and off-time edge cases reachable within a few dozen cycles each.

// File: rtl/long_push_det.sv
module long_push_det #(
  parameter int CW = 16,
  parameter bit FIRE_POWER_OFF = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn_main_n,
  input  logic          btn_aux_n,
  input  logic          run_ok,
  input  logic [CW-1:0] debounce_len,
  input  logic [CW-1:0] minpulse_len,
  input  logic [CW-1:0] extra_len,
  input  logic [CW-1:0] recover_len,
  input  logic [CW-1:0] offtime_len,
  output logic          rst_pulse_n,
  output logic          pwr_off_req,
  output logic          reconfirm_req
);
  localparam int TW = CW + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_QUAL, S_EXTRA, S_RST, S_CONF, S_OFF, S_OFFW, S_WAIT
  } st_t;

  st_t           state;
  logic [TW-1:0] cnt;
  logic          main_prev;
  logic [TW-1:0] qual_len;
  logic          both_down;
  logic          main_fall;
  st_t           fire_st;

  assign qual_len  = {1'b0, debounce_len} + {1'b0, minpulse_len};
  assign both_down = !btn_main_n && !btn_aux_n;
  assign main_fall = main_prev && !btn_main_n;
  assign fire_st   = FIRE_POWER_OFF ? S_OFF : S_RST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      main_prev <= 1'b1;
    end else begin
      main_prev <= btn_main_n;
      case (state)
        S_IDLE:
          if (run_ok && !btn_main_n) begin
            state <= S_QUAL;
            cnt   <= TW'(1);
          end
        S_QUAL:
          if (!run_ok) state <= S_WAIT;
          else if (btn_main_n) state <= S_IDLE;
          else if (cnt >= qual_len) begin
            if (!btn_aux_n) begin
              state <= (extra_len == '0) ? fire_st : S_EXTRA;
              cnt   <= TW'(1);
            end
          end else cnt <= cnt + TW'(1);
        S_EXTRA:
          if (!run_ok || !both_down) state <= S_WAIT;
          else if (cnt >= {1'b0, extra_len}) begin
            state <= fire_st;
            cnt   <= TW'(1);
          end else cnt <= cnt + TW'(1);
        S_RST:
          if (cnt >= {1'b0, recover_len}) state <= S_CONF;
          else cnt <= cnt + TW'(1);
        S_CONF: state <= S_WAIT;
        S_OFF:
          if (cnt >= {1'b0, offtime_len}) state <= S_OFFW;
          else cnt <= cnt + TW'(1);
        S_OFFW:
          if (main_fall) state <= S_WAIT;
        S_WAIT:
          if (btn_main_n && btn_aux_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rst_pulse_n   = (state != S_RST);
  assign pwr_off_req   = (state == S_OFF) || (state == S_OFFW);
  assign reconfirm_req = (state == S_CONF);
endmodule

// File: rtl/long_push_det_chk.sv
module long_push_det_chk #(
  parameter bit FIRE_POWER_OFF = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic btn_main_n,
  input logic btn_aux_n,
  input logic rst_pulse_n,
  input logic pwr_off_req,
  input logic reconfirm_req
);
  AST_FIRE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_pulse_n) || $rose(pwr_off_req)) |-> ($past(!btn_main_n) && $past(!btn_aux_n))); // R2
  AST_CONFIRM_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_n) |-> reconfirm_req); // R6
  AST_CONFIRM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reconfirm_req |=> !reconfirm_req); // R6
  AST_OFF_CLEAR_ON_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_off_req) |-> $past(!btn_main_n)); // R7
  AST_OUTCOMES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_off_req && !rst_pulse_n)); // R11
  AST_MODE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    FIRE_POWER_OFF ? (rst_pulse_n && !reconfirm_req) : !pwr_off_req); // R11
endmodule

bind long_push_det long_push_det_chk #(.FIRE_POWER_OFF(FIRE_POWER_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .btn_main_n(btn_main_n), .btn_aux_n(btn_aux_n),
  .rst_pulse_n(rst_pulse_n), .pwr_off_req(pwr_off_req), .reconfirm_req(reconfirm_req)
);

// File: tb/long_push_det_tb.sv
module long_push_det_tb;
  localparam int CW = 16;
  localparam int Q  = 5;
  localparam int E  = 4;
  localparam int RL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_n = 1'b1, aux_n = 1'b1, run_ok = 1'b1;
  logic [CW-1:0] deb = 16'd3, minp = 16'd2, extra = 16'd4, recov = 16'd5, offt = 16'd6;
  logic r_rst_n, r_off, r_conf, p_rst_n, p_off, p_conf;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  long_push_det #(.CW(CW), .FIRE_POWER_OFF(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_main_n(main_n), .btn_aux_n(aux_n), .run_ok(run_ok),
    .debounce_len(deb), .minpulse_len(minp), .extra_len(extra), .recover_len(recov),
    .offtime_len(offt), .rst_pulse_n(r_rst_n), .pwr_off_req(r_off), .reconfirm_req(r_conf));

  long_push_det #(.CW(CW), .FIRE_POWER_OFF(1'b1)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .btn_main_n(main_n), .btn_aux_n(aux_n), .run_ok(run_ok),
    .debounce_len(deb), .minpulse_len(minp), .extra_len(extra), .recover_len(recov),
    .offtime_len(offt), .rst_pulse_n(p_rst_n), .pwr_off_req(p_off), .reconfirm_req(p_conf));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic restart();
    main_n = 1'b1; aux_n = 1'b1; run_ok = 1'b1; extra = 16'd4;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    tick(2);
    chk("R1 rst_pulse_n in reset", r_rst_n, 1);
    chk("R1 pwr_off_req in reset", p_off, 0);
    chk("R1 reconfirm_req in reset", r_conf, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 idle after reset", {r_rst_n, r_off, r_conf, p_rst_n, p_off, p_conf}, 6'b100100);
  endtask

  task automatic t_aux_first();
    int lows = 0;
    restart();
    aux_n = 1'b0; tick(1);
    main_n = 1'b0;
    tick(Q + E);
    chk("R2 no reset before Q+E", r_rst_n, 1);
    tick(1);
    chk("R2 reset at Q+E", r_rst_n, 0);
    tick(RL - 1);
    chk("R6 reset still low at end", r_rst_n, 0);
    tick(1);
    chk("R6 reset released", r_rst_n, 1);
    chk("R6 reconfirm pulse", r_conf, 1);
    tick(1);
    chk("R6 reconfirm single cycle", r_conf, 0);
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (!r_rst_n || r_conf) lows++;
    end
    chk("R8 no refire while held", lows, 0);
  endtask

  task automatic t_main_first();
    restart();
    main_n = 1'b0;
    tick(8);
    chk("R3 nothing without aux", r_rst_n, 1);
    aux_n = 1'b0;
    tick(E);
    chk("R3 no reset before E after aux", r_rst_n, 1);
    tick(1);
    chk("R3 reset E after aux", r_rst_n, 0);
  endtask

  task automatic t_abort();
    int lows = 0;
    restart();
    aux_n = 1'b0; main_n = 1'b0;
    tick(Q + 2);
    aux_n = 1'b1; tick(1);
    aux_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (!r_rst_n || p_off) lows++;
    end
    chk("R4 abort until both released", lows, 0);
    main_n = 1'b1; aux_n = 1'b1; tick(1);
    aux_n = 1'b0; main_n = 1'b0;
    tick(Q + E + 1);
    chk("R4 re-armed after release", r_rst_n, 0);
  endtask

  task automatic t_zero_extra();
    restart();
    extra = 16'd0;
    aux_n = 1'b0; main_n = 1'b0;
    tick(Q);
    chk("R5 no reset before Q", r_rst_n, 1);
    tick(1);
    chk("R5 reset right after Q", r_rst_n, 0);
  endtask

  task automatic t_power_off();
    restart();
    aux_n = 1'b0; main_n = 1'b0;
    tick(Q + E);
    chk("R7 no power-off before Q+E", p_off, 0);
    tick(1);
    chk("R7 power-off at detection", p_off, 1);
    chk("R11 power mode keeps reset high", p_rst_n, 1);
    chk("R11 reset mode has no power-off", r_off, 0);
    main_n = 1'b1; tick(1);
    main_n = 1'b0; tick(1);
    tick(10);
    chk("R7 press during off time ignored", p_off, 1);
    main_n = 1'b1; tick(1);
    chk("R7 release does not clear", p_off, 1);
    main_n = 1'b0; tick(1);
    chk("R7 new press clears power-off", p_off, 0);
    chk("R11 power mode no reconfirm", p_conf, 0);
  endtask

  task automatic t_not_running();
    int hits = 0;
    restart();
    run_ok = 1'b0;
    aux_n = 1'b0; main_n = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (!r_rst_n || p_off) hits++;
    end
    chk("R9 no outcome while not running", hits, 0);
  endtask

  task automatic t_requal();
    restart();
    aux_n = 1'b0; main_n = 1'b0;
    tick(3);
    main_n = 1'b1; tick(1);
    main_n = 1'b0;
    tick(Q + E);
    chk("R10 count restarted", r_rst_n, 1);
    tick(1);
    chk("R10 reset after full recount", r_rst_n, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset_state();
    t_aux_first();
    t_main_first();
    t_abort();
    t_zero_extra();
    t_power_off();
    t_not_running();
    t_requal();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule